// File: doc/BRIEF.md
# Bubble-Through FIFO Buffer

This block is a first-in first-out buffer of 64 words by 4 bits. It uses no read or write pointers. The storage is a chain of cells. Each cell holds one word and a valid bit. A word taken in at the input stage moves one cell downstream on every clock. It passes over empty cells until it reaches the output stage or a cell that is already occupied. Words therefore collect at the output end, and empty cells drift back toward the input.

The writer and the reader each use a level handshake, and both handshakes run on the same system clock. On the write side, the writer sees a ready flag. It raises a request level to hand over a word, and it must drop that level again before the word is allowed to move on. The read side works the same way, in mirror form. The ready flags also serve as status flags: the write ready flag stays low while the buffer is full, and the read ready flag stays low while the buffer is empty. A synchronous active-high reset empties the buffer.

Top module: `bubble_fifo`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `wr_rdy` is 1, `rd_rdy` is 0 and `rd_data` is 0. Any word held before the reset is discarded and never appears at the output.
- R2: A rising edge of `wr_req`, seen on a clock where `wr_rdy` is 1, captures `wr_data`. `wr_rdy` is 0 after that clock.
- R3: While `wr_req` stays high after a capture, the word stays in the input stage. In that time `wr_rdy` stays 0, and the word does not reach the output.
- R4: A rising edge of `wr_req` while `wr_rdy` is 0 is ignored. No word is stored.
- R5: Words move toward the output on their own. In an empty buffer, `rd_rdy` rises on the 64th clock edge counted from the first edge that samples `wr_req` low after a capture. In general this count equals the depth.
- R6: A rising edge of `rd_req` while `rd_rdy` is 1 drives `rd_rdy` to 0 after that clock. `rd_data` stays unchanged while `rd_req` stays high.
- R7: After `rd_req` falls, the next stored word, if there is one, is loaded into the output stage and `rd_rdy` rises again.
- R8: When the buffer is empty, `rd_rdy` stays 0 and `rd_data` keeps the last word that was delivered.
- R9: The buffer holds exactly 64 words. After 64 writes with no reads, `wr_rdy` stays 0.
- R10: Words leave in the order in which they were written, under any interleaving of writes and reads.
- R11: A rising edge of `rd_req` while `rd_rdy` is 0 is ignored. The next word to arrive is still delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both handshakes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset that empties the buffer |
| wr_req | input | 1 | Write request level; its rising edge offers a word, its falling edge releases it |
| wr_data | input | W | Word captured on an accepted write request |
| wr_rdy | output | 1 | High when the input stage can take a word; low while the buffer is full |
| rd_req | input | 1 | Read request level; its rising edge takes the word, its falling edge frees the output stage |
| rd_data | output | W | Word held in the output stage; keeps its last value when the buffer is empty |
| rd_rdy | output | 1 | High when the output stage holds an unread word; low while the buffer is empty |

## Verification
The hardest state to reach is the full buffer that is then drained while new words are still being written. In that state a space opened at the output has to ripple back through all 62 internal cells in one clock, while the input stage is waiting for a release. The bench fills the buffer to capacity and then tries a write that must be ignored. It drains the buffer in order and confirms that the rejected word never appears. It then runs a long period in which the write and read request levels toggle at random, independently of each other. The output order is compared against a queue model, so the buffer passes through full, empty and partly-filled states with concurrent shifts.

// File: rtl/bf_pkg.sv
package bf_pkg;

  // Edge events derived from a sampled handshake level
  typedef struct packed {
    logic rise;
    logic fall;
  } bf_edge_t;

endpackage

// File: rtl/bf_edge_det.sv
module bf_edge_det (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  output bf_pkg::bf_edge_t ev_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  always_comb begin
    ev_o.rise = lvl_i & ~prev_q;
    ev_o.fall = ~lvl_i & prev_q;
  end

endmodule

// File: rtl/bf_in_stage.sv
module bf_in_stage #(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req_i,
  input  bf_pkg::bf_edge_t ev_i,
  input  logic [W-1:0]     data_i,
  input  logic             room_i,
  output logic             push_o,
  output logic [W-1:0]     data_o,
  output logic             rdy_o
);

  logic         valid_q, held_q;
  logic         valid_nx, held_nx;
  logic         take;
  logic [W-1:0] data_q;

  assign take   = ev_i.rise & rdy_o;
  assign push_o = valid_q & ~held_q & room_i;
  assign data_o = data_q;

  always_comb begin
    valid_nx = valid_q;
    held_nx  = held_q;
    if (take) begin
      valid_nx = 1'b1;
      held_nx  = 1'b1;
    end else if (push_o) begin
      valid_nx = 1'b0;
    end
    if (ev_i.fall) held_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      held_q  <= 1'b0;
      rdy_o   <= 1'b1;
      data_q  <= '0;
    end else begin
      valid_q <= valid_nx;
      held_q  <= held_nx;
      rdy_o   <= ~valid_nx;
      if (take) data_q <= data_i;
    end
  end

  AST_WR_RDY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ev_i.rise && rdy_o) |=> !rdy_o); // R2
  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    (held_q && wr_req_i) |=> (valid_q && $stable(data_q))); // R3
  AST_IGNORE_BUSY_WR: assert property (@(posedge clk) disable iff (rst)
    (ev_i.rise && !rdy_o) |=> $stable(data_q)); // R4

endmodule

// File: rtl/bf_stack.sv
module bf_stack #(
  parameter int W     = 4,
  parameter int CELLS = 62
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         room_o,
  input  logic         take_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);

  logic [CELLS-1:0]        vld;
  logic [CELLS-1:0]        mv;
  logic [CELLS-1:0][W-1:0] dat;

  // Space ripples upstream: a cell may move when its neighbour is empty
  // or is itself moving on this clock.
  always_comb begin
    logic room;
    room = take_i;
    for (int k = CELLS - 1; k >= 0; k--) begin
      mv[k] = vld[k] & room;
      room  = ~vld[k] | mv[k];
    end
    room_o = room;
  end

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    logic         v_q;
    logic [W-1:0] d_q;
    logic         load;
    logic [W-1:0] src;

    if (k == 0) begin : g_head
      assign load = push_i;
      assign src  = data_i;
    end else begin : g_body
      assign load = mv[k-1];
      assign src  = dat[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= load | (v_q & ~mv[k]);
    end

    always_ff @(posedge clk) begin
      if (load) d_q <= src;
    end

    assign vld[k] = v_q;
    assign dat[k] = d_q;
  end

  assign valid_o = vld[CELLS-1];
  assign data_o  = dat[CELLS-1];

  AST_NO_PUSH_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (push_i && vld[0]) |-> mv[0]); // R10

endmodule

// File: rtl/bf_out_stage.sv
module bf_out_stage #(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req_i,
  input  bf_pkg::bf_edge_t ev_i,
  input  logic             up_valid_i,
  input  logic [W-1:0]     up_data_i,
  output logic             take_o,
  output logic             rdy_o,
  output logic [W-1:0]     data_o
);

  logic held_q;
  logic load;

  assign take_o = ~rdy_o & ~held_q;
  assign load   = take_o & up_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_o  <= 1'b0;
      held_q <= 1'b0;
      data_o <= '0;
    end else begin
      if (ev_i.rise && rdy_o) begin
        rdy_o  <= 1'b0;
        held_q <= 1'b1;
      end else if (load) begin
        rdy_o  <= 1'b1;
        data_o <= up_data_i;
      end
      if (ev_i.fall) held_q <= 1'b0;
    end
  end

  AST_RD_RDY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ev_i.rise && rdy_o) |=> !rdy_o); // R6
  AST_DATA_STABLE_READ: assert property (@(posedge clk) disable iff (rst)
    (held_q && rd_req_i) |=> $stable(data_o)); // R6
  AST_IGNORE_IDLE_RD: assert property (@(posedge clk) disable iff (rst)
    (ev_i.rise && !rdy_o && !held_q) |=> !held_q); // R11

endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         wr_rdy,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         rd_rdy
);

  localparam int CELLS = DEPTH - 2;

  bf_pkg::bf_edge_t wr_ev, rd_ev;
  logic             push, room, take, top_valid;
  logic [W-1:0]     in_word, top_word;

  bf_edge_det u_wr_edge (
    .clk(clk), .rst(rst), .lvl_i(wr_req), .ev_o(wr_ev)
  );

  bf_edge_det u_rd_edge (
    .clk(clk), .rst(rst), .lvl_i(rd_req), .ev_o(rd_ev)
  );

  bf_in_stage #(.W(W)) u_in (
    .clk(clk), .rst(rst), .wr_req_i(wr_req), .ev_i(wr_ev),
    .data_i(wr_data), .room_i(room), .push_o(push),
    .data_o(in_word), .rdy_o(wr_rdy)
  );

  bf_stack #(.W(W), .CELLS(CELLS)) u_stack (
    .clk(clk), .rst(rst), .push_i(push), .data_i(in_word),
    .room_o(room), .take_i(take), .valid_o(top_valid), .data_o(top_word)
  );

  bf_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .rd_req_i(rd_req), .ev_i(rd_ev),
    .up_valid_i(top_valid), .up_data_i(top_word),
    .take_o(take), .rdy_o(rd_rdy), .data_o(rd_data)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (wr_rdy && !rd_rdy && rd_data == '0)); // R1

endmodule

// File: tb/bubble_fifo_tb_top.sv
module bubble_fifo_tb_top;

  localparam int W     = 4;
  localparam int DEPTH = 64;
  localparam int NVEC  = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_req = 1'b0;
  logic         wr_rdy, rd_rdy;
  logic [W-1:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] q[$];

  always #4 clk = ~clk;

  bubble_fifo #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .wr_rdy(wr_rdy),
    .rd_req(rd_req), .rd_data(rd_data), .rd_rdy(rd_rdy)
  );

  // {is_read, word}: writes give the word, reads give the expected word
  localparam logic [W:0] VEC [NVEC] = '{
    5'h03, 5'h0A, 5'h05, 5'h0F, 5'h13, 5'h00, 5'h1A, 5'h07,
    5'h15, 5'h09, 5'h1F, 5'h10, 5'h0C, 5'h17, 5'h19, 5'h01,
    5'h1C, 5'h11, 5'h06, 5'h16
  };

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_wr;
    for (int i = 0; i < 300 && !wr_rdy; i++) tick();
  endtask

  task automatic wait_rd;
    for (int i = 0; i < 300 && !rd_rdy; i++) tick();
  endtask

  task automatic do_write(input logic [W-1:0] d);
    wait_wr();
    wr_data = d;
    wr_req  = 1'b1;
    tick();
    check(wr_rdy == 1'b0, "R2 wr_rdy after capture", wr_rdy, 0);
    wr_req = 1'b0;
    tick();
  endtask

  task automatic do_read(input logic [W-1:0] exp);
    wait_rd();
    check(rd_rdy == 1'b1, "R7 rd_rdy before read", rd_rdy, 1);
    check(rd_data == exp, "R10 order", rd_data, exp);
    rd_req = 1'b1;
    tick();
    check(rd_rdy == 1'b0, "R6 rd_rdy after read", rd_rdy, 0);
    check(rd_data == exp, "R6 data stable", rd_data, exp);
    rd_req = 1'b0;
    tick();
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [W-1:0] last;
    int cnt;
    repeat (3) tick();
    check(wr_rdy == 1'b1, "R1 wr_rdy in reset", wr_rdy, 1);
    check(rd_rdy == 1'b0, "R1 rd_rdy in reset", rd_rdy, 0);
    rst = 1'b0;
    tick();
    check(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][W]) do_read(VEC[i][W-1:0]);
      else           do_write(VEC[i][W-1:0]);
    end
    for (int i = 0; i < 80; i++) tick();
    check(rd_rdy == 1'b0, "R8 empty after table", rd_rdy, 0);

    // Hold in input stage, then measure fall-through latency
    wr_data = 4'h9;
    wr_req  = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(wr_rdy == 1'b0 && rd_rdy == 1'b0, "R3 held while request high",
            {wr_rdy, rd_rdy}, 0);
    end
    wr_req = 1'b0;
    cnt = 0;
    for (int i = 0; i < 200 && !rd_rdy; i++) begin
      tick();
      cnt++;
    end
    check(cnt == DEPTH, "R5 fall-through latency", cnt, DEPTH);
    do_read(4'h9);
    last = 4'h9;

    // Empty: output holds last word; read request ignored
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0;
    for (int i = 0; i < 70; i++) tick();
    check(rd_rdy == 1'b0, "R8 rd_rdy empty", rd_rdy, 0);
    check(rd_data == last, "R8 rd_data holds", rd_data, last);
    do_write(4'h6);
    do_read(4'h6);
    check(1'b1, "R11 idle read ignored, next word delivered", 0, 0);

    // Fill to capacity
    for (int k = 0; k < DEPTH; k++) do_write(4'((k * 7 + 3) & 15));
    for (int i = 0; i < 80; i++) tick();
    check(wr_rdy == 1'b0, "R9 full after 64 writes", wr_rdy, 0);
    wr_data = 4'h5;
    wr_req  = 1'b1;
    tick();
    wr_req = 1'b0;
    tick();
    check(wr_rdy == 1'b0, "R4 still full", wr_rdy, 0);
    for (int k = 0; k < DEPTH; k++) do_read(4'((k * 7 + 3) & 15));
    for (int i = 0; i < 80; i++) tick();
    check(rd_rdy == 1'b0, "R4 rejected word absent", rd_rdy, 0);

    // Random interleaving against a queue model
    for (int c = 0; c < 4000; c++) begin
      if (!rd_req && rd_rdy && $urandom_range(1, 0) == 1) begin
        if (q.size() == 0) check(1'b0, "R10 unexpected word", rd_data, 0);
        else begin
          logic [W-1:0] e;
          e = q.pop_front();
          check(rd_data == e, "R10 random order", rd_data, e);
        end
        rd_req = 1'b1;
      end else if (rd_req && $urandom_range(2, 0) != 0) begin
        rd_req = 1'b0;
      end
      if (!wr_req && wr_rdy && $urandom_range(1, 0) == 1) begin
        wr_data = W'($urandom);
        q.push_back(wr_data);
        wr_req = 1'b1;
      end else if (wr_req && $urandom_range(2, 0) != 0) begin
        wr_req = 1'b0;
      end
      tick();
    end
    wr_req = 1'b0;
    rd_req = 1'b0;
    tick();
    while (q.size() > 0) do_read(q.pop_front());
    for (int i = 0; i < 80; i++) tick();
    check(rd_rdy == 1'b0, "R10 drained", rd_rdy, 0);

    // Reset in the middle of traffic
    do_write(4'h1);
    do_write(4'h2);
    do_write(4'h3);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
    check(wr_rdy == 1'b1 && rd_rdy == 1'b0, "R1 state after reset",
          {wr_rdy, rd_rdy}, 2);
    check(rd_data == '0, "R1 data after reset", rd_data, 0);
    for (int i = 0; i < 80; i++) tick();
    check(rd_rdy == 1'b0, "R1 old words discarded", rd_rdy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule